// File: doc/BRIEF.md
# HDLC Data Link Transmit Formatter

This block turns bytes taken from a transmit FIFO into the serial bit stream of a data link channel. A two-bit mode input selects one of four framings. Two are bit-oriented HDLC: one appends a 16-bit frame check sequence on its own, and the other sends the FIFO bytes untouched between flags. The other two are transparent: they send either all eight bits or only the six low bits of every FIFO byte, with no framing at all. The channel is time-shared, so a per-cycle strobe marks the clock cycles that own a link bit. The block advances only on those cycles.

In the HDLC modes the link idles on repeated flag characters. A frame opens on the flag that is being sent when data is found in the FIFO. The block then sends the payload with zero insertion, adds the check sequence when the mode calls for it, and closes with a flag. A software abort request cuts the frame short with eight ones. A FIFO that runs dry before the byte marked end-of-frame also forces an abort, and it raises an interrupt pulse. A completed frame raises the same pulse.

The controller has seven states. `S_FLAG` sends idle or opening flags. At a flag's end it goes to `S_DATA` if the FIFO holds a byte. `S_DATA` sends payload bytes. At the last byte it goes to `S_FCS_LO` in check-sequence mode or to `S_CLOSE` otherwise. If the FIFO runs dry it goes to `S_ABORT`. `S_FCS_LO` and then `S_FCS_HI` send the two check bytes, and `S_FCS_HI` leads to `S_CLOSE`. `S_CLOSE` sends the closing flag and returns to `S_FLAG` with an interrupt pulse. `S_ABORT` sends eight ones and returns to `S_FLAG`. Any payload state (`S_DATA`, `S_FCS_LO`, `S_FCS_HI`) jumps to `S_ABORT` on an abort request. `S_RAW` serves both transparent modes. Whenever `en` is low the machine is forced to `S_FLAG`, or to `S_RAW` when `mode[1]` is set.

Top module: `dl_tx_formatter`

## Requirements
- R1: The mode encoding is 00 = HDLC with automatic check sequence, 01 = HDLC without check sequence, 10 = transparent 8 bits per byte, 11 = transparent 6 bits per byte. While `en` is low, and during reset, `ser_out` is 1, `fifo_rd` stays 0 and `irq` stays 0. The first strobe after `en` rises starts a fresh flag (HDLC) or a fresh byte (transparent).
- R2: In the HDLC modes the block sends the flag 0x7E, LSB first (bit sequence 0,1,1,1,1,1,1,0), for as long as the FIFO is empty. A frame's first byte is popped as the last bit of a flag is sent, so that flag serves as the opening flag.
- R3: In the HDLC modes a 0 is inserted after every five consecutive 1s among the payload and check-sequence bits. The run carries across byte boundaries, no insertion is made inside flags or aborts, and an insertion that falls due after the last payload bit is sent before the closing flag or abort.
- R4: In mode 00, after the byte marked end-of-frame, the block sends the ones-complement of a CRC-16 (x^16+x^12+x^5+1, preset 0xFFFF, data bits fed LSB first), low byte first and LSB first. The closing flag follows it.
- R5: In mode 01, every FIFO byte up to and including the end-of-frame byte is sent LSB first between the opening and closing flags, and no check sequence is added.
- R6: In mode 10, each FIFO byte is sent as eight bits, LSB first, back to back. The block sends 1 on every strobe for which no byte is available. No flags, insertion or check sequence appear.
- R7: In mode 11, only bits 5:0 of each FIFO byte are sent, LSB first, back to back, with the same idle-1 rule as R6.
- R8: `ser_out` changes and `fifo_rd` pulses only on cycles where `strobe` is high. `fifo_rd` is asserted only when `en` is high and the FIFO is not empty.
- R9: If the FIFO is empty when the last bit of a payload byte that is not marked end-of-frame is sent, the block sends 0xFF (after any pending insertion) and then returns to flags. `irq` pulses for one cycle on that same strobe.
- R10: An abort request sampled on a strobe during payload or check-sequence transmission makes `ser_out` 1 on that strobe. Eight ones in total are sent, no insertion is made, and then flags follow. No `irq` is raised.
- R11: When the last bit of a closing flag is sent, `irq` pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmit enable; low forces the idle start state |
| mode | input | 2 | Framing select, encoded as in R1 |
| strobe | input | 1 | High on cycles that carry a link bit |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_eof | input | 1 | Head byte is the last byte of its frame |
| fifo_rd | output | 1 | Pops the head byte at this clock edge |
| abort_req | input | 1 | Request to abort the frame in progress |
| ser_out | output | 1 | Serial link bit, registered |
| irq | output | 1 | One-cycle event: frame done or underrun |

## Verification
Every framing is compared bit for bit against a reference stream. A controller that enters the wrong state or loads the wrong byte corrupts `ser_out` within the next strobe, and at most one byte time later. A drifting bit counter shifts the flag pattern within eight strobes. A ones-run counter that is off by one leaves an insertion missing or extra within five payload bits. A wrong check-sequence register appears in the two bytes right before the closing flag. Event faults are caught by counting `irq` pulses and FIFO pops over each frame window, and by checking that `ser_out` holds on cycles without a strobe.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic [1:0] {
        MODE_FRAMED_FCS  = 2'b00,
        MODE_FRAMED_BARE = 2'b01,
        MODE_TRANS8      = 2'b10,
        MODE_TRANS6      = 2'b11
    } dl_mode_e;

    typedef enum logic [2:0] {
        S_FLAG,
        S_DATA,
        S_FCS_LO,
        S_FCS_HI,
        S_CLOSE,
        S_ABORT,
        S_RAW
    } tx_state_e;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'hFF;

endpackage

// File: rtl/dlf_crc16.sv
// One serial step of a reflected CRC: the shift register moves toward bit 0.
module dlf_crc16 #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    POLY = 16'h8408
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic feedback;

    assign feedback = crc_i[0] ^ bit_i;
    assign crc_o    = (crc_i >> 1) ^ (feedback ? POLY : '0);

endmodule

// File: rtl/dlf_zero_stuff.sv
// Counts consecutive ones among payload bits and flags when a zero is due.
module dlf_zero_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic bit_i,
    output logic stuff_due
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr) begin
            run_q <= '0;
        end else if (adv) begin
            run_q <= bit_i ? run_q + CW'(1) : '0;
        end
    end

    assign stuff_due = (run_q == CW'(RUN));

    // R3: the run never grows past the limit, so a zero always breaks it
    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(RUN));

    // R3: once a zero is due, the controller must clear the run on that cycle
    assert_stuff_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_due |-> !adv);

endmodule

// File: rtl/dl_tx_formatter.sv
module dl_tx_formatter
    import dlf_pkg::*;
#(
    parameter int                  DW        = 8,
    parameter int                  CRC_W     = 16,
    parameter logic [CRC_W-1:0]    CRC_POLY  = 16'h8408,
    parameter logic [CRC_W-1:0]    CRC_INIT  = 16'hFFFF,
    parameter int                  STUFF_RUN = 5,
    parameter int                  NARROW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic          strobe,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_empty,
    input  logic          fifo_eof,
    output logic          fifo_rd,
    input  logic          abort_req,
    output logic          ser_out,
    output logic          irq
);
    localparam int CNT_W = $clog2(DW);

    tx_state_e         st_q, st_d;
    dl_mode_e          mode_e;
    logic [DW-1:0]     sh_q, sh_d;
    logic [DW-1:0]     fcs_hi_q, fcs_hi_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
    logic [CRC_W-1:0]  crc_q, crc_d, crc_next;
    logic              last_q, last_d;
    logic              have_q, have_d;
    logic              ser_d, irq_d;
    logic              ones_clr, ones_adv, stuff_due;
    logic              in_payload, payload_abort;

    assign mode_e        = dl_mode_e'(mode);
    assign last_idx      = (mode_e == MODE_TRANS6) ? CNT_W'(NARROW - 1) : CNT_W'(DW - 1);
    assign in_payload    = (st_q == S_DATA) || (st_q == S_FCS_LO) || (st_q == S_FCS_HI);
    assign payload_abort = en && strobe && abort_req && in_payload;

    dlf_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_i (crc_q),
        .bit_i (sh_q[0]),
        .crc_o (crc_next)
    );

    dlf_zero_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ones_clr),
        .adv       (ones_adv),
        .bit_i     (sh_q[0]),
        .stuff_due (stuff_due)
    );

    // Next-state and output decode
    always_comb begin
        st_d     = st_q;
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        crc_d    = crc_q;
        fcs_hi_d = fcs_hi_q;
        last_d   = last_q;
        have_d   = have_q;
        ser_d    = ser_out;
        irq_d    = 1'b0;
        fifo_rd  = 1'b0;
        ones_clr = 1'b0;
        ones_adv = 1'b0;
        if (!en) begin
            st_d     = mode[1] ? S_RAW : S_FLAG;
            sh_d     = FLAG_BYTE;
            cnt_d    = '0;
            have_d   = 1'b0;
            last_d   = 1'b0;
            ser_d    = 1'b1;
            ones_clr = 1'b1;
        end else if (strobe) begin
            if (st_q == S_RAW) begin
                if (have_q) begin
                    ser_d = sh_q[0];
                    sh_d  = sh_q >> 1;
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == last_idx) begin
                        cnt_d = '0;
                        if (!fifo_empty) begin
                            fifo_rd = 1'b1;
                            sh_d    = fifo_data;
                        end else begin
                            have_d = 1'b0;
                        end
                    end
                end else if (!fifo_empty) begin
                    fifo_rd = 1'b1;
                    ser_d   = fifo_data[0];
                    sh_d    = fifo_data >> 1;
                    cnt_d   = CNT_W'(1);
                    have_d  = 1'b1;
                end else begin
                    ser_d = 1'b1;
                end
            end else if (in_payload && abort_req) begin
                st_d     = S_ABORT;
                ser_d    = 1'b1;
                sh_d     = ABORT_BYTE >> 1;
                cnt_d    = CNT_W'(1);
                ones_clr = 1'b1;
            end else if (stuff_due) begin
                ser_d    = 1'b0;
                ones_clr = 1'b1;
            end else begin
                ser_d = sh_q[0];
                sh_d  = sh_q >> 1;
                cnt_d = cnt_q + CNT_W'(1);
                if (in_payload) ones_adv = 1'b1;
                else            ones_clr = 1'b1;
                if (st_q == S_DATA) crc_d = crc_next;
                if (cnt_q == last_idx) begin
                    cnt_d = '0;
                    unique case (st_q)
                        S_FLAG: begin
                            if (!fifo_empty) begin
                                fifo_rd = 1'b1;
                                sh_d    = fifo_data;
                                last_d  = fifo_eof;
                                crc_d   = CRC_INIT;
                                st_d    = S_DATA;
                            end else begin
                                sh_d = FLAG_BYTE;
                            end
                        end
                        S_DATA: begin
                            if (last_q) begin
                                if (mode_e == MODE_FRAMED_FCS) begin
                                    st_d     = S_FCS_LO;
                                    sh_d     = ~crc_next[DW-1:0];
                                    fcs_hi_d = ~crc_next[2*DW-1:DW];
                                end else begin
                                    st_d = S_CLOSE;
                                    sh_d = FLAG_BYTE;
                                end
                            end else if (fifo_empty) begin
                                st_d  = S_ABORT;
                                sh_d  = ABORT_BYTE;
                                irq_d = 1'b1;
                            end else begin
                                fifo_rd = 1'b1;
                                sh_d    = fifo_data;
                                last_d  = fifo_eof;
                            end
                        end
                        S_FCS_LO: begin
                            st_d = S_FCS_HI;
                            sh_d = fcs_hi_q;
                        end
                        S_FCS_HI: begin
                            st_d = S_CLOSE;
                            sh_d = FLAG_BYTE;
                        end
                        S_CLOSE: begin
                            st_d  = S_FLAG;
                            sh_d  = FLAG_BYTE;
                            irq_d = 1'b1;
                        end
                        S_ABORT: begin
                            st_d = S_FLAG;
                            sh_d = FLAG_BYTE;
                        end
                        default: begin
                            st_d = S_FLAG;
                        end
                    endcase
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= S_FLAG;
            sh_q     <= FLAG_BYTE;
            cnt_q    <= '0;
            crc_q    <= CRC_INIT;
            fcs_hi_q <= '0;
            last_q   <= 1'b0;
            have_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            sh_q     <= sh_d;
            cnt_q    <= cnt_d;
            crc_q    <= crc_d;
            fcs_hi_q <= fcs_hi_d;
            last_q   <= last_d;
            have_q   <= have_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_out <= 1'b1;
            irq     <= 1'b0;
        end else begin
            ser_out <= ser_d;
            irq     <= irq_d;
        end
    end

    // R8: a pop only happens in an enabled strobe cycle with data present
    assert_pop_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (en && strobe && !fifo_empty));

    // R8: no strobe, no change on the line
    assert_line_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(strobe)) |-> $stable(ser_out));

    // R1: a disabled cycle leaves the line marking and the event quiet
    assert_quiet_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (ser_out && !irq));

    // R10: an accepted abort request puts a one on the line at once
    assert_abort_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(payload_abort) |-> (ser_out && st_q == S_ABORT));

    // R11: the event is a single-cycle pulse
    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

// File: tb/sim_dl_tx_formatter.sv
module sim_dl_tx_formatter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic strobe = 1'b0;
    logic abort_req = 1'b0;
    logic fifo_clr = 1'b1;
    logic [1:0] mode = 2'b00;

    logic [7:0] fmem [0:7];
    logic       feof [0:7];
    int         flen = 0;
    int         fptr = 0;

    logic [7:0] fifo_data;
    logic       fifo_empty, fifo_eof, fifo_rd, ser_out, irq;

    int   checks = 0;
    int   fails = 0;
    int   nexp = 0;
    int   ones_run = 0;
    logic exp_bits [0:511];

    // Vector: mode[39:38] len[37:35] eof[34] exp_irq[33:32] bytes b0..b3 [31:0]
    localparam logic [39:0] VEC [8] = '{
        {2'b00, 3'd3, 1'b1, 2'd1, 8'h12, 8'h34, 8'h56, 8'h00},
        {2'b00, 3'd2, 1'b1, 2'd1, 8'hFF, 8'hFF, 8'h00, 8'h00},
        {2'b01, 3'd4, 1'b1, 2'd1, 8'h7E, 8'h3E, 8'hF8, 8'h01},
        {2'b01, 3'd1, 1'b1, 2'd1, 8'hF8, 8'h00, 8'h00, 8'h00},
        {2'b10, 3'd3, 1'b0, 2'd0, 8'hA5, 8'h3C, 8'h81, 8'h00},
        {2'b11, 3'd3, 1'b0, 2'd0, 8'hFF, 8'hC1, 8'h2A, 8'h00},
        {2'b00, 3'd2, 1'b0, 2'd1, 8'h0F, 8'hF8, 8'h00, 8'h00},
        {2'b01, 3'd1, 1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    always #4 clk = ~clk;

    assign fifo_empty = (fptr >= flen);
    assign fifo_data  = fmem[fptr[2:0]];
    assign fifo_eof   = feof[fptr[2:0]];

    always @(posedge clk) begin
        if (fifo_clr)     fptr <= 0;
        else if (fifo_rd) fptr <= fptr + 1;
    end

    dl_tx_formatter u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode       (mode),
        .strobe     (strobe),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fifo_eof   (fifo_eof),
        .fifo_rd    (fifo_rd),
        .abort_req  (abort_req),
        .ser_out    (ser_out),
        .irq        (irq)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic b);
        exp_bits[nexp] = b;
        nexp++;
    endtask

    task automatic push_plain(input logic [7:0] x);
        for (int j = 0; j < 8; j++) push(x[j]);
    endtask

    task automatic push_stuffed(input logic [7:0] x);
        for (int j = 0; j < 8; j++) begin
            push(x[j]);
            ones_run = x[j] ? ones_run + 1 : 0;
            if (ones_run == 5) begin
                push(1'b0);
                ones_run = 0;
            end
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] vbyte(input logic [39:0] v, input int i);
        return v[31 - 8*i -: 8];
    endfunction

    // Reference stream from the requirements (R2..R7, R9)
    task automatic build(input logic [39:0] v);
        logic [1:0]  md;
        int          len;
        logic [15:0] crc;
        md  = v[39:38];
        len = int'(v[37:35]);
        nexp = 0;
        if (md[1]) begin
            for (int i = 0; i < len; i++)
                for (int j = 0; j < ((md == 2'b11) ? 6 : 8); j++) push(vbyte(v, i)[j]);
            for (int j = 0; j < 4; j++) push(1'b1);
        end else begin
            push_plain(8'h7E);
            ones_run = 0;
            crc = 16'hFFFF;
            for (int i = 0; i < len; i++) begin
                push_stuffed(vbyte(v, i));
                crc = crc_byte(crc, vbyte(v, i));
            end
            if (v[34]) begin
                if (md == 2'b00) begin
                    push_stuffed(~crc[7:0]);
                    push_stuffed(~crc[15:8]);
                end
                push_plain(8'h7E);
                push_plain(8'h7E);
            end else begin
                push_plain(8'hFF);
                push_plain(8'h7E);
            end
        end
    endtask

    task automatic load_fifo(input logic [39:0] v);
        flen = int'(v[37:35]);
        for (int i = 0; i < 8; i++) begin
            fmem[i] = (i < 4) ? vbyte(v, i) : 8'h00;
            feof[i] = (i == flen - 1) && v[34];
        end
    endtask

    task automatic prepare(input logic [39:0] v);
        load_fifo(v);
        @(negedge clk);
        en = 1'b0;
        strobe = 1'b0;
        mode = v[39:38];
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int mism, first_k, first_act, first_exp, irqs, bad, rds, idx;
        logic prev;
        string tag;
        for (int i = 0; i < 8; i++) begin
            fmem[i] = 8'h00;
            feof[i] = 1'b0;
        end

        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        check(ser_out === 1'b1, "R1", "ser_out in reset", int'(ser_out), 1);
        check(irq === 1'b0, "R1", "irq in reset", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        fifo_clr = 1'b0;
        @(posedge clk);
        #2;
        check(fifo_rd === 1'b0, "R1", "fifo_rd after reset", int'(fifo_rd), 0);

        // R1: disabled with data waiting and strobes running
        load_fifo({2'b00, 3'd2, 1'b1, 2'd1, 8'h5A, 8'h33, 16'h0});
        @(negedge clk);
        strobe = 1'b1;
        bad = 0;
        rds = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            #2;
            if (ser_out !== 1'b1 || irq !== 1'b0) bad++;
            if (fifo_rd !== 1'b0) rds++;
        end
        check(bad == 0, "R1", "line or irq active while disabled", bad, 0);
        check(rds == 0 && fptr == 0, "R1", "FIFO pops while disabled", fptr, 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R9 R11
        for (int v = 0; v < 8; v++) begin
            prepare(VEC[v]);
            build(VEC[v]);
            unique case (VEC[v][39:38])
                2'b00:   tag = VEC[v][34] ? "R4/R2/R3" : "R9/R3";
                2'b01:   tag = "R5/R2/R3";
                2'b10:   tag = "R6";
                default: tag = "R7";
            endcase
            en = 1'b1;
            strobe = 1'b1;
            mism = 0;
            first_k = -1;
            first_act = 0;
            first_exp = 0;
            irqs = 0;
            for (int k = 0; k < nexp; k++) begin
                @(posedge clk);
                #2;
                if (ser_out !== exp_bits[k]) begin
                    if (first_k < 0) begin
                        first_k = k;
                        first_act = int'(ser_out);
                        first_exp = int'(exp_bits[k]);
                    end
                    mism++;
                end
                if (irq === 1'b1) irqs++;
            end
            if (mism != 0)
                $display("  vector %0d first bad bit index %0d", v, first_k);
            check(mism == 0, tag, "stream bit", first_act, first_exp);
            check(irqs == int'(VEC[v][33:32]), "R11/R9", "irq pulses", irqs, int'(VEC[v][33:32]));
            check(fptr == int'(VEC[v][37:35]), "R8", "bytes popped", fptr, int'(VEC[v][37:35]));
            @(negedge clk);
            en = 1'b0;
            strobe = 1'b0;
        end

        // R8: sparse strobes in 8-bit transparent mode
        prepare({2'b10, 3'd2, 1'b0, 2'd0, 8'hA5, 8'h0F, 16'h0});
        build({2'b10, 3'd2, 1'b0, 2'd0, 8'hA5, 8'h0F, 16'h0});
        en = 1'b1;
        idx = 0;
        mism = 0;
        bad = 0;
        prev = ser_out;
        for (int c = 0; c < 200 && idx < nexp; c++) begin
            @(negedge clk);
            strobe = (c % 3 == 0);
            rds = fptr;
            @(posedge clk);
            #2;
            if (strobe) begin
                if (ser_out !== exp_bits[idx]) mism++;
                idx++;
            end else begin
                if (ser_out !== prev || fptr != rds) bad++;
            end
            prev = ser_out;
        end
        check(mism == 0, "R8/R6", "sparse-strobe stream mismatches", mism, 0);
        check(bad == 0, "R8", "changes on non-strobe cycles", bad, 0);
        @(negedge clk);
        en = 1'b0;
        strobe = 1'b0;

        // R10: abort request after four payload bits
        prepare({2'b01, 3'd2, 1'b1, 2'd0, 8'h00, 8'h55, 16'h0});
        nexp = 0;
        push_plain(8'h7E);
        for (int j = 0; j < 4; j++) push(1'b0);
        for (int j = 0; j < 8; j++) push(1'b1);
        push_plain(8'h7E);
        en = 1'b1;
        strobe = 1'b1;
        mism = 0;
        irqs = 0;
        for (int k = 0; k < nexp; k++) begin
            abort_req = (k == 12);
            @(posedge clk);
            #2;
            if (ser_out !== exp_bits[k]) mism++;
            if (irq === 1'b1) irqs++;
        end
        abort_req = 1'b0;
        check(mism == 0, "R10", "abort stream mismatches", mism, 0);
        check(irqs == 0, "R10", "irq on requested abort", irqs, 0);
        @(negedge clk);
        en = 1'b0;
        strobe = 1'b0;

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule